// File: doc/BRIEF.md
# Serial Flash Write-Permission and Auto-Increment Program Controller

This block sits behind the command front end of a serial flash and decides which write commands reach the array core. It watches a per-frame stream: the chip-select level, an opcode strobe and the byte strobes that follow the opcode. Each instruction is committed when chip select is released. At that point the block keeps the write-enable latch up to date, applies the rule that a status-register write only counts when it directly follows its arming instruction, and issues a one-cycle grant that names the kind of write and carries its address.

Word programming with automatic address increment is sequenced here. The first auto-increment instruction brings a full address and one data word. Every later one brings only a data word, and the block supplies the next address itself. Between frames the block can also drive a ready/busy level onto the serial output while this mode is active. The core answers every granted operation with a done pulse, which ends the busy phase.

Top module: `wpa_ctrl`

## Requirements
- R1: After reset, `wel`, `busy`, `aai_mode`, `grant`, `word_valid` and `rb_oe` are all 0.
- R2: A frame with opcode 06h sets `wel`. A frame with opcode 04h clears it.
- R3: While `wel` is 0, opcodes 02h, ADh, 20h, D8h, 60h and C7h produce no grant.
- R4: When `wel` is 1 and `busy` is 0, a 02h frame carrying 3 address bytes (most significant first) and 1 data byte grants kind 1. It sets `prog_addr` to the address, sets `word_data` to {8'h00, data} and sets `busy`. A later `op_done` clears both `busy` and `wel`.
- R5: 20h with 3 address bytes grants kind 3 and D8h with 3 address bytes grants kind 4. 60h and C7h need no bytes and grant kind 5.
- R6: A 01h frame that carries at least one byte grants kind 6 only when the frame directly before it was 50h. Any other frame in between cancels the arming. The later `op_done` clears `wel`.
- R7: While `busy` is 1, every write command and 01h is rejected with no grant.
- R8: A first ADh frame carrying 3 address bytes and data bytes D0, D1 grants kind 2. It enters `aai_mode`, loads `prog_addr`, pulses `word_valid` with `word_data` = {D0, D1}, and sets `busy`.
- R9: In `aai_mode`, an ADh frame carrying two data bytes advances `prog_addr` by 2 and emits a word. `op_done` clears `busy` but leaves `wel` set. Any other write command is rejected in this mode.
- R10: Opcode 04h leaves `aai_mode` and clears `wel`.
- R11: After 70h, `rb_oe` is 1 whenever `aai_mode` is 1 and `sel_active` is 0, and `rb_out` equals the inverse of `busy`. After 80h, `rb_oe` stays 0.
- R12: A frame that ends before it holds the bytes its opcode needs gives no grant and changes no state.
- R13: Each result takes effect at the first rising clock edge that samples `sel_active` low after a frame. `grant` and `word_valid` are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_active | input | 1 | High while chip select is asserted |
| op_stb | input | 1 | Opcode byte valid (first byte of a frame) |
| op_code | input | 8 | Opcode value |
| byte_stb | input | 1 | Following byte valid |
| byte_val | input | 8 | Following byte value |
| op_done | input | 1 | Core finished the granted operation |
| wel | output | 1 | Write-enable latch |
| busy | output | 1 | Granted operation in progress |
| aai_mode | output | 1 | Auto-increment programming active |
| grant | output | 1 | One-cycle grant pulse |
| grant_kind | output | 3 | 1 program, 2 auto-inc word, 3 sector, 4 block, 5 chip, 6 status |
| prog_addr | output | AW (24) | Address of the granted operation |
| word_valid | output | 1 | Auto-increment word pulse |
| word_data | output | 16 | Data for the granted program |
| rb_oe | output | 1 | Drive ready/busy onto serial output |
| rb_out | output | 1 | Ready level (1 = ready) |

## Verification
Each committed frame updates the registered outputs at the rising edge that first samples `sel_active` low. Each bench task drops chip select just after a falling edge and reads the results at the next falling edge, one edge after the commit. A `grant` or `word_valid` pulse is low again half a cycle later, and the bench reads that as well. `op_done` clears `busy` at the edge that samples it, so it is read at the following falling edge. The values of `rb_oe` and `rb_out` follow `sel_active` and the registered state within the same cycle, so they are read between frames.

// File: rtl/wpa_pkg.sv
package wpa_pkg;

    typedef enum logic [3:0] {
        K_NONE, K_WREN, K_WRDI, K_EWSR, K_WRSR, K_PROG, K_AAI,
        K_SERASE, K_BERASE, K_CERASE, K_EBSY, K_DBSY
    } op_kind_e;

    typedef enum logic [2:0] {
        G_NONE  = 3'd0,
        G_PROG  = 3'd1,
        G_AAI   = 3'd2,
        G_SECT  = 3'd3,
        G_BLK   = 3'd4,
        G_CHIP  = 3'd5,
        G_STAT  = 3'd6
    } grant_e;

    function automatic logic is_array_write(op_kind_e k);
        return (k == K_PROG) || (k == K_AAI) || (k == K_SERASE) ||
               (k == K_BERASE) || (k == K_CERASE);
    endfunction

endpackage

// File: rtl/wpa_decode.sv
module wpa_decode
    import wpa_pkg::*;
(
    input  logic [7:0] code,
    output op_kind_e   kind
);
    always_comb begin
        case (code)
            8'h06:   kind = K_WREN;
            8'h04:   kind = K_WRDI;
            8'h50:   kind = K_EWSR;
            8'h01:   kind = K_WRSR;
            8'h02:   kind = K_PROG;
            8'hAD:   kind = K_AAI;
            8'h20:   kind = K_SERASE;
            8'hD8:   kind = K_BERASE;
            8'h60,
            8'hC7:   kind = K_CERASE;
            8'h70:   kind = K_EBSY;
            8'h80:   kind = K_DBSY;
            default: kind = K_NONE;
        endcase
    end
endmodule

// File: rtl/wpa_frame.sv
module wpa_frame
    import wpa_pkg::*;
#(
    parameter int NB = 5,
    localparam int CW = $clog2(NB + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel_active,
    input  logic            op_stb,
    input  op_kind_e        op_kind,
    input  logic            byte_stb,
    input  logic [7:0]      byte_val,
    output logic            fr_end,
    output op_kind_e        fr_kind,
    output logic [CW-1:0]   fr_cnt,
    output logic [NB*8-1:0] fr_bytes
);
    typedef struct packed {
        logic                 sel;
        op_kind_e             kind;
        logic [CW-1:0]        cnt;
        logic [NB-1:0][7:0]   bytes;
    } fr_state_t;

    fr_state_t f_d, f_q;

    assign fr_end  = f_q.sel & ~sel_active;
    assign fr_kind = f_q.kind;
    assign fr_cnt  = f_q.cnt;

    for (genvar i = 0; i < NB; i++) begin : g_out
        assign fr_bytes[8*i +: 8] = f_q.bytes[i];
    end

    always_comb begin
        f_d = f_q;
        f_d.sel = sel_active;
        if (fr_end) begin
            f_d.kind = K_NONE;
            f_d.cnt  = '0;
        end
        if (sel_active && op_stb) begin
            f_d.kind = op_kind;
            f_d.cnt  = '0;
        end else if (sel_active && byte_stb && (f_q.cnt < CW'(NB))) begin
            f_d.bytes[f_q.cnt] = byte_val;
            f_d.cnt = f_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    // byte count never runs past the buffer (R12)
    assert_cnt_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.cnt <= CW'(NB));

endmodule

// File: rtl/wpa_ctrl.sv
module wpa_ctrl
    import wpa_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_active,
    input  logic          op_stb,
    input  logic [7:0]    op_code,
    input  logic          byte_stb,
    input  logic [7:0]    byte_val,
    input  logic          op_done,
    output logic          wel,
    output logic          busy,
    output logic          aai_mode,
    output logic          grant,
    output logic [2:0]    grant_kind,
    output logic [AW-1:0] prog_addr,
    output logic          word_valid,
    output logic [15:0]   word_data,
    output logic          rb_oe,
    output logic          rb_out
);
    localparam int AB = AW / 8;
    localparam int NB = AB + 2;
    localparam int CW = $clog2(NB + 1);

    op_kind_e        dec_kind;
    logic            fr_end;
    op_kind_e        fr_kind;
    logic [CW-1:0]   fr_cnt;
    logic [NB*8-1:0] fr_bytes;
    logic [AW-1:0]   fr_addr;

    wpa_decode u_dec (.code(op_code), .kind(dec_kind));

    wpa_frame #(.NB(NB)) u_frame (
        .clk(clk), .rst_n(rst_n), .sel_active(sel_active),
        .op_stb(op_stb), .op_kind(dec_kind),
        .byte_stb(byte_stb), .byte_val(byte_val),
        .fr_end(fr_end), .fr_kind(fr_kind), .fr_cnt(fr_cnt), .fr_bytes(fr_bytes)
    );

    // address bytes arrive most significant first
    for (genvar i = 0; i < AB; i++) begin : g_addr
        assign fr_addr[8*(AB-1-i) +: 8] = fr_bytes[8*i +: 8];
    end

    typedef struct packed {
        logic          wel;
        logic          busy;
        logic          aai;
        logic          arm;
        logic          rb_en;
        logic          grant;
        grant_e        gkind;
        logic [AW-1:0] addr;
        logic          wvalid;
        logic [15:0]   wdata;
    } ctl_state_t;

    ctl_state_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.grant  = 1'b0;
        s_d.gkind  = G_NONE;
        s_d.wvalid = 1'b0;
        if (op_done && s_q.busy) begin
            s_d.busy = 1'b0;
            if (!s_q.aai) s_d.wel = 1'b0;
        end
        if (fr_end) begin
            s_d.arm = 1'b0;
            case (fr_kind)
                K_WREN: s_d.wel = 1'b1;
                K_WRDI: begin
                    s_d.wel = 1'b0;
                    s_d.aai = 1'b0;
                end
                K_EWSR: s_d.arm   = 1'b1;
                K_EBSY: s_d.rb_en = 1'b1;
                K_DBSY: s_d.rb_en = 1'b0;
                K_WRSR: begin
                    if (s_q.arm && !s_q.busy && fr_cnt >= CW'(1)) begin
                        s_d.grant = 1'b1;
                        s_d.gkind = G_STAT;
                        s_d.busy  = 1'b1;
                    end
                end
                default: begin
                    if (is_array_write(fr_kind) && s_q.wel && !s_q.busy) begin
                        if (s_q.aai) begin
                            if (fr_kind == K_AAI && fr_cnt >= CW'(2)) begin
                                s_d.grant  = 1'b1;
                                s_d.gkind  = G_AAI;
                                s_d.addr   = s_q.addr + AW'(2);
                                s_d.wvalid = 1'b1;
                                s_d.wdata  = {fr_bytes[7:0], fr_bytes[15:8]};
                                s_d.busy   = 1'b1;
                            end
                        end else begin
                            case (fr_kind)
                                K_PROG: if (fr_cnt >= CW'(AB + 1)) begin
                                    s_d.grant = 1'b1;
                                    s_d.gkind = G_PROG;
                                    s_d.addr  = fr_addr;
                                    s_d.wdata = {8'h00, fr_bytes[8*AB +: 8]};
                                    s_d.busy  = 1'b1;
                                end
                                K_AAI: if (fr_cnt >= CW'(AB + 2)) begin
                                    s_d.grant  = 1'b1;
                                    s_d.gkind  = G_AAI;
                                    s_d.aai    = 1'b1;
                                    s_d.addr   = fr_addr;
                                    s_d.wvalid = 1'b1;
                                    s_d.wdata  = {fr_bytes[8*AB +: 8], fr_bytes[8*(AB+1) +: 8]};
                                    s_d.busy   = 1'b1;
                                end
                                K_SERASE, K_BERASE: if (fr_cnt >= CW'(AB)) begin
                                    s_d.grant = 1'b1;
                                    s_d.gkind = (fr_kind == K_SERASE) ? G_SECT : G_BLK;
                                    s_d.addr  = fr_addr;
                                    s_d.busy  = 1'b1;
                                end
                                K_CERASE: begin
                                    s_d.grant = 1'b1;
                                    s_d.gkind = G_CHIP;
                                    s_d.busy  = 1'b1;
                                end
                                default: ;
                            endcase
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.gkind <= G_NONE;
        end else begin
            s_q <= s_d;
        end
    end

    assign wel        = s_q.wel;
    assign busy       = s_q.busy;
    assign aai_mode   = s_q.aai;
    assign grant      = s_q.grant;
    assign grant_kind = s_q.gkind;
    assign prog_addr  = s_q.addr;
    assign word_valid = s_q.wvalid;
    assign word_data  = s_q.wdata;
    assign rb_oe      = s_q.rb_en & s_q.aai & ~sel_active;
    assign rb_out     = rb_oe & ~s_q.busy;

    // array writes need the latch set and the core idle (R3, R7)
    assert_write_needs_wel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && grant_kind != G_STAT) |-> $past(s_q.wel && !s_q.busy));

    // status write needs the arming frame just before (R6)
    assert_status_armed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && grant_kind == G_STAT) |-> $past(s_q.arm));

    // follow-on auto-increment word steps the address by two (R9)
    assert_aai_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && $past(s_q.aai)) |-> (prog_addr == $past(prog_addr) + AW'(2)));

    // done always ends the busy phase (R4)
    assert_done_clears_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_done) |=> !busy);

    // a granted operation leaves the block busy (R7)
    assert_grant_sets_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> busy);

    // pulses last a single cycle (R13)
    assert_grant_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> !grant);

    // ready/busy is only driven in auto-increment mode (R11)
    assert_rb_in_aai_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rb_oe |-> aai_mode);

endmodule

// File: tb/wpa_ctrl_tb_top.sv
`timescale 1ns/1ps
module wpa_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_active = 1'b0;
    logic        op_stb = 1'b0;
    logic [7:0]  op_code = 8'h00;
    logic        byte_stb = 1'b0;
    logic [7:0]  byte_val = 8'h00;
    logic        op_done = 1'b0;
    logic        wel, busy, aai_mode, grant, word_valid, rb_oe, rb_out;
    logic [2:0]  grant_kind;
    logic [23:0] prog_addr;
    logic [15:0] word_data;

    int checks = 0;
    int errors = 0;
    logic        c_grant, c_wv;
    logic [2:0]  c_kind;

    always #2 clk = ~clk;

    wpa_ctrl #(.AW(24)) dut_i (
        .clk(clk), .rst_n(rst_n), .sel_active(sel_active),
        .op_stb(op_stb), .op_code(op_code), .byte_stb(byte_stb), .byte_val(byte_val),
        .op_done(op_done), .wel(wel), .busy(busy), .aai_mode(aai_mode),
        .grant(grant), .grant_kind(grant_kind), .prog_addr(prog_addr),
        .word_valid(word_valid), .word_data(word_data), .rb_oe(rb_oe), .rb_out(rb_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one frame: opcode, n following bytes (bs[39:32] first), then release
    task automatic frame(input logic [7:0] op, input int n, input logic [39:0] bs);
        @(negedge clk);
        sel_active = 1'b1; op_stb = 1'b1; op_code = op;
        @(negedge clk);
        op_stb = 1'b0;
        for (int i = 0; i < n; i++) begin
            byte_stb = 1'b1;
            byte_val = bs[39-8*i -: 8];
            @(negedge clk);
        end
        byte_stb = 1'b0;
        sel_active = 1'b0;
        @(negedge clk);
        c_grant = grant; c_kind = grant_kind; c_wv = word_valid;
    endtask

    task automatic done_pulse();
        @(negedge clk); op_done = 1'b1;
        @(negedge clk); op_done = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 wel", wel, 0);       chk("R1 busy", busy, 0);
        chk("R1 aai", aai_mode, 0);  chk("R1 grant", grant, 0);
        chk("R1 wv", word_valid, 0); chk("R1 rb_oe", rb_oe, 0);
    endtask

    task automatic t_latch();
        frame(8'h06, 0, '0); chk("R2 set", wel, 1);
        frame(8'h04, 0, '0); chk("R2 clear", wel, 0);
    endtask

    task automatic t_locked();
        frame(8'h02, 4, 40'h0102030400); chk("R3 prog", c_grant, 0);
        frame(8'hAD, 5, 40'h0102030405); chk("R3 aai", c_grant, 0);
        chk("R3 aai mode", aai_mode, 0);
        frame(8'h20, 3, 40'h0102030000); chk("R3 sector", c_grant, 0);
        frame(8'hC7, 0, '0);             chk("R3 chip", c_grant, 0);
        chk("R3 busy", busy, 0);
    endtask

    task automatic t_program();
        frame(8'h06, 0, '0);
        frame(8'h02, 4, 40'h12345677_00);
        chk("R4 grant", c_grant, 1); chk("R4 kind", c_kind, 1);
        chk("R4 addr", prog_addr, 24'h123456); chk("R4 data", word_data, 16'h0077);
        chk("R4 busy", busy, 1);
        @(negedge clk); chk("R13 pulse", grant, 0);
        // busy rejects everything that writes
        frame(8'h20, 3, 40'hAAAAAA0000); chk("R7 erase while busy", c_grant, 0);
        frame(8'h50, 0, '0);
        frame(8'h01, 1, 40'h5500000000); chk("R7 status while busy", c_grant, 0);
        done_pulse();
        chk("R4 busy cleared", busy, 0); chk("R4 wel cleared", wel, 0);
    endtask

    task automatic t_erase();
        frame(8'h06, 0, '0);
        frame(8'h20, 3, 40'h0A1000_0000); chk("R5 sector kind", c_kind, 3);
        chk("R5 sector addr", prog_addr, 24'h0A1000); done_pulse();
        frame(8'h06, 0, '0);
        frame(8'hD8, 3, 40'h0B0000_0000); chk("R5 block kind", c_kind, 4);
        chk("R5 block addr", prog_addr, 24'h0B0000); done_pulse();
        frame(8'h06, 0, '0);
        frame(8'h60, 0, '0); chk("R5 chip 60", c_kind, 5); done_pulse();
        frame(8'h06, 0, '0);
        frame(8'hC7, 0, '0); chk("R5 chip C7", c_kind, 5); done_pulse();
    endtask

    task automatic t_status();
        frame(8'h01, 1, 40'h3C00000000); chk("R6 unarmed", c_grant, 0);
        frame(8'h50, 0, '0);
        frame(8'h06, 0, '0);
        frame(8'h01, 1, 40'h3C00000000); chk("R6 gap cancels", c_grant, 0);
        frame(8'h50, 0, '0);
        frame(8'h01, 1, 40'h3C00000000);
        chk("R6 granted", c_grant, 1); chk("R6 kind", c_kind, 6);
        done_pulse(); chk("R6 wel cleared", wel, 0);
    endtask

    task automatic t_short();
        frame(8'h06, 0, '0);
        frame(8'h02, 3, 40'h0506070000); chk("R12 short prog", c_grant, 0);
        chk("R12 busy", busy, 0); chk("R12 addr kept", prog_addr, 24'h0B0000);
        frame(8'hAD, 4, 40'h0506070800); chk("R12 short aai", c_grant, 0);
        chk("R12 aai", aai_mode, 0);
        frame(8'h04, 0, '0);
    endtask

    task automatic t_aai();
        frame(8'h70, 0, '0);
        frame(8'h06, 0, '0);
        frame(8'hAD, 5, 40'h012344A1B2);
        chk("R8 kind", c_kind, 2); chk("R8 wv", c_wv, 1);
        chk("R8 mode", aai_mode, 1); chk("R8 addr", prog_addr, 24'h012344);
        chk("R8 data", word_data, 16'hA1B2); chk("R8 busy", busy, 1);
        chk("R11 oe", rb_oe, 1); chk("R11 busy level", rb_out, 0);
        @(negedge clk); chk("R13 wv pulse", word_valid, 0);
        done_pulse();
        chk("R11 ready level", rb_out, 1);
        chk("R9 busy cleared", busy, 0); chk("R9 wel kept", wel, 1);
        frame(8'hAD, 2, 40'hC3D4000000);
        chk("R9 wv", c_wv, 1); chk("R9 addr", prog_addr, 24'h012346);
        chk("R9 data", word_data, 16'hC3D4); done_pulse();
        frame(8'h20, 3, 40'h0000000000); chk("R9 other write rejected", c_grant, 0);
        frame(8'h80, 0, '0); chk("R11 disabled", rb_oe, 0);
        frame(8'h04, 0, '0);
        chk("R10 mode off", aai_mode, 0); chk("R10 wel off", wel, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_latch();
        t_locked();
        t_program();
        t_erase();
        t_status();
        t_short();
        t_aai();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule